// File: doc/BRIEF.md
# Paged Sample-Scan Register Controller

This block is the bus-facing register file and scan sequencer for a 32-input sampling front end. A host reaches it through an 8-bit data port with a 4-bit address. A write and a read at the same address usually reach different registers. Through this port the host sets a first and a last input channel and a sample configuration, controls a sample FIFO, enables interrupts, selects a register page and starts conversions.

A start request converts either the first channel alone or, with scanning on, every channel from the first channel upward to the last channel. The channel count wraps from 31 back to 0. A converter model inside the block takes a fixed number of cycles for each conversion. It combines the external sample input with the channel number and stores the result in the FIFO. When the final sample of a scan is stored, a conversion flag is set and an interrupt can be raised.

After any change to the channel or configuration registers, a settling timer runs. While it runs, a wait bit reads as set and start requests are refused.

Top module: `adcscan_ctrl`

## Requirements
- R1: After reset, or after a full reset followed by writing 0x0C to offset 11 and letting the settling time pass, the FIFO status read at offset 7 is exactly 0x80 (empty only), offset 9 reads 0x00 and offset 11 reads 0x0C. Directly after reset, offset 11 and offsets 2 and 3 read 0x00.
- R2: The first-channel register (offset 2) and the last-channel register (offset 3) keep only bits 4:0. Writing 0x80 reads back 0x00, and writing 0xFF reads back 0x1F.
- R3: A write to offset 2, 3 or 11 starts a settling window of SETTLE_CYCLES cycles. During the window, bit 7 of the offset 11 read is 1. Bits 5:0 of that read echo the configuration written (interval 5:4, 10 V range bit 3, unipolar bit 2, gain 1:0), and bit 6 reads 0.
- R4: Any write to offset 0 starts a conversion. With scanning off, only the first channel is converted. While a conversion runs, the offset 8 read has bit 7 set, and its bits 4:0 give the channel being converted. Each sample is {adc_in[15:5], adc_in[4:0] XOR channel}.
- R5: With scanning on (FIFO control bit 2), one sample is taken per channel. The channels run upward from the first channel and wrap from 31 to 0, and the scan ends after the last channel.
- R6: A start request is ignored while a conversion or scan is running, or while the settling window is open.
- R7: The FIFO control write at offset 7 enables the FIFO with bit 3 and flushes it with bit 1. The status read shows empty in bit 7, half full (count of at least DEPTH/2) in bit 6 and full in bit 5. Reading offset 0 returns the low byte of the oldest sample. Reading offset 1 returns its high byte and removes it.
- R8: A sample that arrives while the FIFO is full is dropped and sets the overflow bit (status bit 4). The overflow bit stays set until a FIFO flush or a full reset.
- R9: The conversion flag is set when the last sample of a scan is stored (for a single conversion, that one sample). The irq output is the flag ANDed with bit 7 of the offset 9 register. The flag is held until a write to offset 8 with bit 3 set.
- R10: Bits 1:0 of an offset 8 write select the page, which is shown in status bits 1:0. Status bits 3:2 echo the FIFO-enable and scan-enable bits.
- R11: A write to offset 8 with bit 5 set returns every register, the FIFO, the flag and the sequencer to their reset state.
- R12: With the FIFO disabled, samples are not queued: the FIFO stays empty, and offsets 0 and 1 return the most recent sample.
- R13: Offset 9 stores bits 7, 6, 5, 1 and 0 of a write and reads back 0 in bits 4:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read of offset 1 removes a FIFO entry |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| adc_in | input | 16 | Converter model input |
| irq | output | 1 | Conversion interrupt request |

## Verification
The bench builds the block with a 4-entry FIFO, a 12-cycle settling window and 3-cycle conversions. With a 4-entry FIFO, a four-channel scan fills it exactly and a five-channel scan overflows it, so the full, half-full and sticky-overflow cases fall within short scans. A 12-cycle window lets the bench watch the wait bit rise and clear, and try a refused start inside the window, without long idle stretches. A scan from channel 30 to channel 1 checks the wrap through the channel number in each stored sample.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;

    localparam int CHAN_W   = 5;
    localparam int SAMPLE_W = 16;

    localparam logic [3:0] OFS_DATA_LO = 4'd0;
    localparam logic [3:0] OFS_DATA_HI = 4'd1;
    localparam logic [3:0] OFS_CH_LO   = 4'd2;
    localparam logic [3:0] OFS_CH_HI   = 4'd3;
    localparam logic [3:0] OFS_FIFO    = 4'd7;
    localparam logic [3:0] OFS_CTRL    = 4'd8;
    localparam logic [3:0] OFS_INTCLK  = 4'd9;
    localparam logic [3:0] OFS_CFG     = 4'd11;

    typedef struct packed {
        logic [1:0] interval;
        logic       range10;
        logic       unipolar;
        logic [1:0] gain;
    } samp_cfg_t;

    typedef struct packed {
        logic conv_ie;
        logic dig_ie;
        logic tmr_ie;
        logic clk_en;
        logic clk_sel;
    } intclk_t;

    function automatic logic [CHAN_W-1:0] chan_next(input logic [CHAN_W-1:0] c);
        return c + 1'b1;
    endfunction

    function automatic logic [7:0] intclk_byte(input intclk_t ic);
        return {ic.conv_ie, ic.dig_ie, ic.tmr_ie, 3'b000, ic.clk_en, ic.clk_sel};
    endfunction

endpackage

// File: rtl/adcscan_settle.sv
module adcscan_settle #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic wait_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (kick)
            cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign wait_o = (cnt != '0);
endmodule

// File: rtl/adcscan_seq.sv
module adcscan_seq
    import adcscan_pkg::*;
#(
    parameter int CONV_CYCLES = 40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                scan_en,
    input  logic [CHAN_W-1:0]   ch_lo,
    input  logic [CHAN_W-1:0]   ch_hi,
    input  logic [SAMPLE_W-1:0] adc_in,
    output logic                busy,
    output logic [CHAN_W-1:0]   chan,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                scan_done
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] RELOAD = CW'(CONV_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          last;

    assign last      = !scan_en || (chan == ch_hi);
    assign smp_valid = busy && (cnt == '0);
    assign scan_done = smp_valid && last;
    assign smp_data  = {adc_in[SAMPLE_W-1:CHAN_W], adc_in[CHAN_W-1:0] ^ chan};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            chan <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                chan <= ch_lo;
                cnt  <= RELOAD;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (last) begin
            busy <= 1'b0;
        end else begin
            chan <= chan_next(chan);
            cnt  <= RELOAD;
        end
    end
endmodule

// File: rtl/adcscan_fifo.sv
module adcscan_fifo
    import adcscan_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] din,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] dout,
    output logic                empty,
    output logic                half,
    output logic                full,
    output logic                ovf
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wp, rp;
    logic [CNT_W-1:0]    count;
    logic                push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign half    = (count >= CNT_W'(DEPTH / 2));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok)
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop_ok)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)
                count <= count + 1'b1;
            else if (pop_ok && !push_ok)
                count <= count - 1'b1;
            if (push && full)
                ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/adcscan_ctrl.sv
module adcscan_ctrl
    import adcscan_pkg::*;
#(
    parameter int FIFO_DEPTH    = 16,
    parameter int SETTLE_CYCLES = 1000,
    parameter int CONV_CYCLES   = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] adc_in,
    output logic        irq
);
    logic                rst_all, fifo_flush, settle_kick, settle_wait, start;
    logic                wr_ctrl;
    logic [CHAN_W-1:0]   ch_lo, ch_hi, chan;
    samp_cfg_t           cfg;
    intclk_t             ic;
    logic                fifo_en, scan_en, irq_flag;
    logic [1:0]          page;
    logic                busy, smp_valid, scan_done;
    logic [SAMPLE_W-1:0] smp_data, latest, fifo_dout, rd_word;
    logic                empty, half, full, ovf, pop;

    assign wr_ctrl     = bus_wr && (bus_addr == OFS_CTRL);
    assign rst_all     = rst || (wr_ctrl && bus_wdata[5]);
    assign fifo_flush  = bus_wr && (bus_addr == OFS_FIFO) && bus_wdata[1];
    assign settle_kick = bus_wr && ((bus_addr == OFS_CH_LO) || (bus_addr == OFS_CH_HI)
                                    || (bus_addr == OFS_CFG));
    assign start       = bus_wr && (bus_addr == OFS_DATA_LO) && !settle_wait;
    assign pop         = bus_rd && (bus_addr == OFS_DATA_HI) && fifo_en;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            ch_lo    <= '0;
            ch_hi    <= '0;
            cfg      <= '0;
            ic       <= '0;
            fifo_en  <= 1'b0;
            scan_en  <= 1'b0;
            page     <= '0;
            irq_flag <= 1'b0;
            latest   <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    OFS_CH_LO:  ch_lo <= bus_wdata[CHAN_W-1:0];
                    OFS_CH_HI:  ch_hi <= bus_wdata[CHAN_W-1:0];
                    OFS_CFG:    cfg   <= samp_cfg_t'(bus_wdata[5:0]);
                    OFS_INTCLK: ic    <= '{conv_ie: bus_wdata[7], dig_ie: bus_wdata[6],
                                           tmr_ie: bus_wdata[5], clk_en: bus_wdata[1],
                                           clk_sel: bus_wdata[0]};
                    OFS_FIFO: begin
                        fifo_en <= bus_wdata[3];
                        scan_en <= bus_wdata[2];
                    end
                    OFS_CTRL:   page  <= bus_wdata[1:0];
                    default: ;
                endcase
            end
            if (smp_valid)
                latest <= smp_data;
            if (scan_done)
                irq_flag <= 1'b1;
            else if (wr_ctrl && bus_wdata[3])
                irq_flag <= 1'b0;
        end
    end

    adcscan_settle #(.CYCLES(SETTLE_CYCLES)) i_settle (
        .clk    (clk),
        .rst    (rst_all),
        .kick   (settle_kick),
        .wait_o (settle_wait)
    );

    adcscan_seq #(.CONV_CYCLES(CONV_CYCLES)) i_seq (
        .clk       (clk),
        .rst       (rst_all),
        .start     (start),
        .scan_en   (scan_en),
        .ch_lo     (ch_lo),
        .ch_hi     (ch_hi),
        .adc_in    (adc_in),
        .busy      (busy),
        .chan      (chan),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .scan_done (scan_done)
    );

    adcscan_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk   (clk),
        .rst   (rst_all),
        .flush (fifo_flush),
        .push  (smp_valid && fifo_en),
        .din   (smp_data),
        .pop   (pop),
        .dout  (fifo_dout),
        .empty (empty),
        .half  (half),
        .full  (full),
        .ovf   (ovf)
    );

    assign rd_word = fifo_en ? fifo_dout : latest;
    assign irq     = irq_flag && ic.conv_ie;

    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            OFS_DATA_LO: bus_rdata = rd_word[7:0];
            OFS_DATA_HI: bus_rdata = rd_word[15:8];
            OFS_CH_LO:   bus_rdata = {3'b000, ch_lo};
            OFS_CH_HI:   bus_rdata = {3'b000, ch_hi};
            OFS_FIFO:    bus_rdata = {empty, half, full, ovf, fifo_en, scan_en, page};
            OFS_CTRL:    bus_rdata = {busy, 2'b00, chan};
            OFS_INTCLK:  bus_rdata = intclk_byte(ic);
            OFS_CFG:     bus_rdata = {settle_wait, 1'b0, cfg};
            default:     bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/adcscan_ctrl_chk.sv
module adcscan_ctrl_chk (
    input logic       clk,
    input logic       rst_all,
    input logic       bus_wr,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       smp_valid,
    input logic       scan_done,
    input logic [4:0] chan,
    input logic       busy,
    input logic       settle_wait,
    input logic       fifo_flush,
    input logic       full,
    input logic       empty,
    input logic       ovf,
    input logic       irq_flag
);
    // R5: inside a scan the next conversion uses the following channel, modulo 32
    a_r5_scan_step: assert property (@(posedge clk) disable iff (rst_all)
        smp_valid && !scan_done |=> chan == $past(chan) + 5'd1);

    // R6: an idle sequencer stays idle while the settling window is open
    a_r6_start_blocked: assert property (@(posedge clk) disable iff (rst_all)
        settle_wait && !busy |=> !busy);

    // R3: a configuration write opens the settling window
    a_r3_settle_kick: assert property (@(posedge clk) disable iff (rst_all)
        bus_wr && bus_addr == 4'd11 |=> settle_wait);

    // R7: full and empty never hold together
    a_r7_full_empty: assert property (@(posedge clk) disable iff (rst_all)
        !(full && empty));

    // R8: overflow is sticky until a flush
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst_all)
        ovf && !fifo_flush |=> ovf);

    // R9: end of scan sets the flag, and the flag holds until cleared
    a_r9_flag_set: assert property (@(posedge clk) disable iff (rst_all)
        scan_done |=> irq_flag);

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst_all)
        irq_flag && !(bus_wr && bus_addr == 4'd8 && bus_wdata[3]) |=> irq_flag);
endmodule

bind adcscan_ctrl adcscan_ctrl_chk i_chk (
    .clk         (clk),
    .rst_all     (rst_all),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .smp_valid   (smp_valid),
    .scan_done   (scan_done),
    .chan        (chan),
    .busy        (busy),
    .settle_wait (settle_wait),
    .fifo_flush  (fifo_flush),
    .full        (full),
    .empty       (empty),
    .ovf         (ovf),
    .irq_flag    (irq_flag)
);

// File: tb/test_adcscan_ctrl.sv
module test_adcscan_ctrl;
    localparam int DEPTH  = 4;
    localparam int SETTLE = 12;
    localparam int CONV   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] adc_in = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adcscan_ctrl #(.FIFO_DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE), .CONV_CYCLES(CONV)) i_adcscan_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .adc_in    (adc_in),
        .irq       (irq)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic pop_check(input string tag, input logic [15:0] exp);
        logic [7:0] lo, hi;
        rd(4'd0, lo);
        rd(4'd1, hi);
        check(tag, {hi, lo}, exp);
    endtask

    task automatic wait_settle();
        repeat (SETTLE + 2) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        for (int i = 0; i < 200; i++) begin
            rd(4'd8, d);
            if (!d[7]) break;
        end
    endtask

    task automatic t_reset();
        rd_check("R1 status after reset", 4'd7, 8'h80);
        rd_check("R1 intclk after reset", 4'd9, 8'h00);
        rd_check("R1 cfg after reset", 4'd11, 8'h00);
        rd_check("R1 lo chan after reset", 4'd2, 8'h00);
        rd_check("R1 hi chan after reset", 4'd3, 8'h00);
        check("R9 irq low after reset", irq, 0);
    endtask

    task automatic t_chan_mask();
        wr(4'd2, 8'h80);
        wr(4'd3, 8'hFF);
        rd_check("R2 lo keeps 5 bits", 4'd2, 8'h00);
        rd_check("R2 hi keeps 5 bits", 4'd3, 8'h1F);
        wait_settle();
    endtask

    task automatic t_settle();
        wr(4'd8, 8'h20);
        wr(4'd11, 8'h0C);
        rd_check("R3 wait bit during settle", 4'd11, 8'h8C);
        wait_settle();
        rd_check("R1 cfg after settle", 4'd11, 8'h0C);
        rd_check("R1 status after full reset", 4'd7, 8'h80);
        wr(4'd11, 8'h3F);
        wait_settle();
        rd_check("R3 cfg echo bits 5:0", 4'd11, 8'h3F);
    endtask

    task automatic t_single();
        wr(4'd7, 8'h08);
        wr(4'd2, 8'h05);
        wr(4'd3, 8'h09);
        wait_settle();
        adc_in = 16'hABC0;
        wr(4'd0, 8'hFF);
        rd_check("R4 busy with first channel", 4'd8, 8'h85);
        wait_idle();
        rd_check("R4 one sample queued", 4'd7, 8'h08);
        check("R9 irq masked while disabled", irq, 0);
        pop_check("R4 single sample value", 16'hABC5);
        rd_check("R7 empty after pop", 4'd7, 8'h88);
        wr(4'd9, 8'h80);
        @(negedge clk);
        check("R9 irq after single conversion", irq, 1);
        wr(4'd8, 8'h08);
        @(negedge clk);
        check("R9 irq cleared", irq, 0);
    endtask

    task automatic t_scan_wrap();
        wr(4'd7, 8'h0C);
        wr(4'd2, 8'd30);
        wr(4'd3, 8'd1);
        wait_settle();
        adc_in = 16'h1240;
        wr(4'd0, 8'h00);
        wait_idle();
        rd_check("R7 full and half after 4 samples", 4'd7, 8'h6C);
        check("R9 irq after scan", irq, 1);
        pop_check("R5 sample ch30", 16'h125E);
        pop_check("R5 sample ch31", 16'h125F);
        pop_check("R5 sample ch0 after wrap", 16'h1240);
        pop_check("R5 sample ch1", 16'h1241);
        rd_check("R7 empty after scan drained", 4'd7, 8'h8C);
        check("R9 irq still held", irq, 1);
        wr(4'd8, 8'h08);
        @(negedge clk);
        check("R9 irq cleared after scan", irq, 0);
    endtask

    task automatic t_overflow();
        wr(4'd7, 8'h0E);
        wr(4'd2, 8'd0);
        wr(4'd3, 8'd4);
        wait_settle();
        adc_in = 16'h5A00;
        wr(4'd0, 8'h00);
        wait_idle();
        rd_check("R8 overflow with full", 4'd7, 8'h7C);
        pop_check("R8 oldest kept ch0", 16'h5A00);
        rd_check("R8 overflow sticky after pop", 4'd7, 8'h5C);
        pop_check("R8 ch1", 16'h5A01);
        pop_check("R8 ch2", 16'h5A02);
        pop_check("R8 ch3, ch4 dropped", 16'h5A03);
        rd_check("R8 overflow held when empty", 4'd7, 8'h9C);
        wr(4'd7, 8'h0E);
        rd_check("R8 flush clears overflow", 4'd7, 8'h8C);
    endtask

    task automatic t_start_ignored();
        wr(4'd7, 8'h08);
        wr(4'd2, 8'd7);
        wr(4'd3, 8'd7);
        wait_settle();
        adc_in = 16'h3300;
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h00);
        wait_idle();
        repeat (CONV + 2) @(negedge clk);
        rd_check("R6 only one sample while busy", 4'd7, 8'h08);
        pop_check("R6 sample ch7", 16'h3307);
        wr(4'd11, 8'h0C);
        wr(4'd0, 8'h00);
        rd_check("R6 start refused while settling", 4'd8, 8'h07);
        repeat (CONV + 2) @(negedge clk);
        rd_check("R6 nothing queued after refused start", 4'd7, 8'h88);
        wait_settle();
    endtask

    task automatic t_page_intclk();
        wr(4'd8, 8'h20);
        wr(4'd8, 8'h03);
        rd_check("R10 page 3 shown", 4'd7, 8'h83);
        wr(4'd7, 8'h04);
        rd_check("R10 scan enable echoed", 4'd7, 8'h87);
        wr(4'd9, 8'hFF);
        rd_check("R13 intclk stored bits", 4'd9, 8'hE3);
    endtask

    task automatic t_full_reset();
        wr(4'd2, 8'h11);
        wr(4'd8, 8'h20);
        rd_check("R11 status after full reset", 4'd7, 8'h80);
        rd_check("R11 intclk after full reset", 4'd9, 8'h00);
        rd_check("R11 lo chan after full reset", 4'd2, 8'h00);
        rd_check("R11 wait bit cleared", 4'd11, 8'h00);
    endtask

    task automatic t_fifo_off();
        wr(4'd7, 8'h00);
        wr(4'd2, 8'd3);
        wr(4'd3, 8'd3);
        wait_settle();
        adc_in = 16'h7700;
        wr(4'd0, 8'h00);
        wait_idle();
        rd_check("R12 fifo stays empty", 4'd7, 8'h80);
        pop_check("R12 latest sample", 16'h7703);
        pop_check("R12 latest not consumed", 16'h7703);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_chan_mask();
        t_settle();
        t_single();
        t_scan_wrap();
        t_overflow();
        t_start_ignored();
        t_page_intclk();
        t_full_reset();
        t_fifo_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule